// File: doc/BRIEF.md
# Instanced attribute index unit

This unit maps a 32-bit linear thread index onto the element index used to fetch a vertex attribute when draws are instanced. The dispatcher pads the vertex count to an odd factor (1, 3, 5, 7 or 9) times a power of two. The attribute stage then needs one of three mappings: the index unchanged, the index reduced modulo the padded count, or the index divided by a constant. The constant is either a power of two or an arbitrary divisor. An arbitrary divisor is applied as a reciprocal multiplier that software computes ahead of time.

Each request carries the index, a two-bit mode, a five-bit shift, a three-bit auxiliary field and a 32-bit multiplier. The unit has two register stages. The first stage registers the request together with the high half of the multiply. The second stage does the shift, the odd-factor reduction and the mode select. A result leaves two cycles after its request, and one request can be accepted on every cycle.

Top module: `attr_elem_index`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, `out_valid` is 0.
- R2: Every cycle with `in_valid` high gives exactly one cycle with `out_valid` high two clock edges later. Requests on consecutive cycles come out on consecutive cycles, in order.
- R3: Mode 2'b00 (pass-through) returns the linear index unchanged.
- R4: Mode 2'b01 (modulo) returns `lin_id mod ((2*xtra+1) * 2^shift_amt)` for `xtra` from 0 to 4. The low `shift_amt` bits of the result equal those of the index.
- R5: Mode 2'b10 (power-of-two divide) returns `lin_id >> shift_amt`.
- R6: Mode 2'b11 (reciprocal divide) with `xtra[0]`=0 returns bits 63..32 of `lin_id * M`, shifted right by `shift_amt`. M is `magic` with bit 31 set. The index is not shifted before the multiply.
- R7: In mode 2'b11, bit 31 of `magic` has no effect on the result. The unit always treats it as 1.
- R8: In mode 2'b11 with `xtra[0]`=1, the result is bits 63..32 of `(lin_id+1) * M`, shifted right by `shift_amt`. This holds without wrap even for `lin_id` = 0xFFFFFFFF and `magic` = 0xFFFFFFFF.
- R9: Software derives the constants for a divisor d ≥ 1 as follows: s = floor(log2 d), m = ceil(2^(s+32)/d), e = 2^(s+32) mod d. If e ≤ 2^s it uses multiplier m−1 with `xtra[0]`=1; otherwise it uses multiplier m with `xtra[0]`=0. With these constants, mode 2'b11 returns floor(lin_id / d).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Request strobe |
| lin_id | input | 32 | Linear thread index |
| mode | input | 2 | 00 pass, 01 modulo, 10 shift divide, 11 reciprocal divide |
| shift_amt | input | 5 | Power-of-two exponent or final right shift |
| xtra | input | 3 | Odd-factor selector (modulo) or round-down enable in bit 0 (reciprocal divide) |
| magic | input | 32 | Reciprocal multiplier; bit 31 is ignored |
| out_valid | output | 1 | Result strobe, two cycles after `in_valid` |
| elem_idx | output | 32 | Attribute element index |

## Verification
The remainder-range property assumes that `xtra` never exceeds 4 in modulo mode. No odd factor beyond 9 is defined, so the stimulus only draws the selector from 0 to 4. The exact-quotient property (R9) holds only for constants built by the stated derivation. The stimulus therefore computes every multiplier, shift and round-down flag from the chosen divisor using that rule. It then compares the result against a plain integer division. The raw-multiply checks (R6, R8) accept any multiplier and any shift. The stimulus flips bit 31 of the multiplier on otherwise identical requests.

// File: rtl/aidx_pkg.sv
`timescale 1ns/1ps
package aidx_pkg;
    localparam int IDW         = 32;
    localparam int SHW         = $clog2(IDW);
    localparam int XTW         = 3;
    localparam int REMW        = 4;
    localparam int MAX_ODD_SEL = 4;

    typedef enum logic [1:0] {
        AM_PASS   = 2'd0,
        AM_MOD    = 2'd1,
        AM_DIVP2  = 2'd2,
        AM_DIVMAG = 2'd3
    } amode_e;

    typedef struct packed {
        amode_e           mode;
        logic [SHW-1:0]   sh;
        logic [XTW-1:0]   xt;
        logic [IDW-1:0]   id;
        logic [IDW-1:0]   hi;
    } stage_t;

    // odd factor 2*sel+1
    function automatic logic [REMW-1:0] odd_of(input logic [XTW-1:0] sel);
        return REMW'({sel, 1'b1});
    endfunction

    function automatic logic [IDW-1:0] low_mask(input logic [SHW-1:0] sh);
        return (IDW'(1) << sh) - IDW'(1);
    endfunction
endpackage

// File: rtl/aidx_magic_mul.sv
`timescale 1ns/1ps
module aidx_magic_mul
    import aidx_pkg::*;
(
    input  logic [IDW-1:0] id,
    input  logic [IDW-1:0] magic,
    input  logic           round_dn,
    output logic [IDW-1:0] hi
);
    localparam int PW = 2 * IDW + 1;
    localparam logic [IDW-1:0] TOP_BIT = {1'b1, {(IDW-1){1'b0}}};

    logic [IDW-1:0] m_eff;
    logic [PW-1:0]  prod;
    logic [PW-1:0]  acc;

    // multiplier always lies in [2^31, 2^32)
    assign m_eff = magic | TOP_BIT;
    assign prod  = PW'(id) * PW'(m_eff);
    // (id+1)*M formed as id*M + M, one spare bit of headroom
    assign acc   = prod + (round_dn ? PW'(m_eff) : '0);
    assign hi    = IDW'(acc >> IDW);

    // R8
    always_comb begin
        no_overflow_chk: assert (acc[PW-1] == 1'b0);
    end
endmodule

// File: rtl/aidx_odd_mod.sv
`timescale 1ns/1ps
module aidx_odd_mod
    import aidx_pkg::*;
(
    input  logic [IDW-1:0]  val,
    input  logic [XTW-1:0]  sel,
    output logic [REMW-1:0] rem
);
    logic [REMW-1:0] cand [MAX_ODD_SEL+1];

    for (genvar k = 0; k <= MAX_ODD_SEL; k++) begin : g_res
        localparam int unsigned DIV = 2 * k + 1;
        assign cand[k] = REMW'(val % IDW'(DIV));
    end

    always_comb begin
        rem = '0;
        for (int k = 0; k <= MAX_ODD_SEL; k++) begin
            if (sel == XTW'(k)) rem = cand[k];
        end
    end
endmodule

// File: rtl/attr_elem_index.sv
`timescale 1ns/1ps
module attr_elem_index
    import aidx_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [IDW-1:0]  lin_id,
    input  logic [1:0]      mode,
    input  logic [SHW-1:0]  shift_amt,
    input  logic [XTW-1:0]  xtra,
    input  logic [IDW-1:0]  magic,
    output logic            out_valid,
    output logic [IDW-1:0]  elem_idx
);
    amode_e          in_mode;
    logic [IDW-1:0]  mul_hi;
    stage_t          s1_d;
    stage_t          s1_q;
    logic            v1;

    assign in_mode = amode_e'(mode);

    // stage 1: reciprocal multiply
    aidx_magic_mul u_mul (
        .id       (lin_id),
        .magic    (magic),
        .round_dn ((in_mode == AM_DIVMAG) && xtra[0]),
        .hi       (mul_hi)
    );

    always_comb begin
        s1_d.mode = in_mode;
        s1_d.sh   = shift_amt;
        s1_d.xt   = xtra;
        s1_d.id   = lin_id;
        s1_d.hi   = mul_hi;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            v1   <= 1'b0;
            s1_q <= '0;
        end else begin
            v1 <= in_valid;
            if (in_valid) s1_q <= s1_d;
        end
    end

    // stage 2: shift, odd reduction, select
    logic [IDW-1:0]  upper;
    logic [IDW-1:0]  low_bits;
    logic [IDW-1:0]  mod_res;
    logic [IDW-1:0]  res;
    logic [REMW-1:0] rem;

    assign upper    = s1_q.id >> s1_q.sh;
    assign low_bits = s1_q.id & low_mask(s1_q.sh);

    aidx_odd_mod u_mod (
        .val (upper),
        .sel (s1_q.xt),
        .rem (rem)
    );

    assign mod_res = (IDW'(rem) << s1_q.sh) | low_bits;

    always_comb begin
        case (s1_q.mode)
            AM_PASS:   res = s1_q.id;
            AM_MOD:    res = mod_res;
            AM_DIVP2:  res = upper;
            AM_DIVMAG: res = s1_q.hi >> s1_q.sh;
            default:   res = s1_q.id;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            elem_idx  <= '0;
        end else begin
            out_valid <= v1;
            elem_idx  <= res;
        end
    end

    // R1
    rst_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);
    // R2
    lat_on_chk: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> ##1 out_valid);
    // R2
    lat_off_chk: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ##1 !out_valid);
    // R3
    pass_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == AM_PASS) |=> ##1 (elem_idx == $past(lin_id, 2)));
    // R5
    pow2_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == AM_DIVP2) |=> ##1
        (elem_idx == ($past(lin_id, 2) >> $past(shift_amt, 2))));
    // R4
    mod_low_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == AM_MOD) |=> ##1
        (((elem_idx ^ $past(lin_id, 2)) & low_mask($past(shift_amt, 2))) == '0));
    // R4
    odd_rem_chk: assert property (@(posedge clk) disable iff (rst)
        (v1 && s1_q.mode == AM_MOD && s1_q.xt <= XTW'(MAX_ODD_SEL)) |-> (rem < odd_of(s1_q.xt)));
    // R6
    mag_bound_chk: assert property (@(posedge clk) disable iff (rst)
        (in_valid && in_mode == AM_DIVMAG) |=> ##1
        (elem_idx <= ($past(lin_id, 2) >> $past(shift_amt, 2))));
endmodule

// File: tb/sim_attr_elem_index.sv
`timescale 1ns/1ps
module sim_attr_elem_index;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] lin_id = '0;
    logic [1:0]  mode = '0;
    logic [4:0]  shift_amt = '0;
    logic [2:0]  xtra = '0;
    logic [31:0] magic = '0;
    logic        out_valid;
    logic [31:0] elem_idx;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2 clk = ~clk;  // 250 MHz

    attr_elem_index u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid), .lin_id(lin_id),
        .mode(mode), .shift_amt(shift_amt), .xtra(xtra), .magic(magic),
        .out_valid(out_valid), .elem_idx(elem_idx)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %0h expected %0h", req, got, exp);
        end
    endtask

    // one request, sampled two edges later
    task automatic run_one(input string req, input logic [31:0] id, input logic [1:0] md,
                           input logic [4:0] sh, input logic [2:0] xt, input logic [31:0] mg,
                           input logic [31:0] exp);
        @(negedge clk);
        in_valid = 1'b1; lin_id = id; mode = md; shift_amt = sh; xtra = xt; magic = mg;
        @(negedge clk);
        in_valid = 1'b0; lin_id = $urandom(); magic = $urandom();
        @(negedge clk);
        check(req, {31'b0, out_valid}, 32'd1);
        check(req, elem_idx, exp);
    endtask

    function automatic logic [31:0] raw_mul(input logic [31:0] id, input logic [31:0] mg,
                                            input logic rd, input logic [4:0] sh);
        logic [63:0] mf = {32'b0, 1'b1, mg[30:0]};
        logic [63:0] p  = {32'b0, id} * mf + (rd ? mf : 64'd0);
        return p[63:32] >> sh;
    endfunction

    task automatic t_reset();
        @(negedge clk);
        check("R1 during reset", {31'b0, out_valid}, 32'd0);
        rst = 1'b0;
        @(negedge clk);
        check("R1 after reset", {31'b0, out_valid}, 32'd0);
    endtask

    task automatic t_pass();
        run_one("R3 zero", 32'd0, 2'b00, 5'd7, 3'd2, 32'h1234, 32'd0);
        run_one("R3 max", 32'hFFFF_FFFF, 2'b00, 5'd31, 3'd4, 32'h0, 32'hFFFF_FFFF);
        for (int i = 0; i < 8; i++) begin
            logic [31:0] id = $urandom();
            run_one("R3 random", id, 2'b00, 5'($urandom()), 3'($urandom()), $urandom(), id);
        end
    endtask

    task automatic t_mod();
        logic [4:0] shs [5] = '{5'd0, 5'd1, 5'd4, 5'd17, 5'd31};
        for (int m = 0; m <= 4; m++) begin
            for (int j = 0; j < 5; j++) begin
                logic [63:0] modv = 64'(2 * m + 1) << shs[j];
                logic [31:0] id = $urandom();
                run_one("R4 random", id, 2'b01, shs[j], 3'(m), $urandom(),
                        32'({32'b0, id} % modv));
            end
        end
        // boundary: exactly the modulus and one below (9*2^3 = 72)
        run_one("R4 id=mod-1", 32'd71, 2'b01, 5'd3, 3'd4, 32'h0, 32'd71);
        run_one("R4 id=mod", 32'd72, 2'b01, 5'd3, 3'd4, 32'h0, 32'd0);
        run_one("R4 id=2mod+5", 32'd149, 2'b01, 5'd3, 3'd4, 32'h0, 32'd5);
        run_one("R4 odd=1", 32'hDEAD_BEEF, 2'b01, 5'd8, 3'd0, 32'h0, 32'h0000_00EF);
    endtask

    task automatic t_pow2();
        run_one("R5 sh0", 32'h8000_0001, 2'b10, 5'd0, 3'd0, 32'h0, 32'h8000_0001);
        run_one("R5 sh31", 32'hFFFF_FFFF, 2'b10, 5'd31, 3'd0, 32'h0, 32'd1);
        for (int i = 0; i < 6; i++) begin
            logic [31:0] id = $urandom();
            logic [4:0] sh = 5'($urandom());
            run_one("R5 random", id, 2'b10, sh, 3'd0, $urandom(), id >> sh);
        end
    endtask

    task automatic t_raw();
        for (int i = 0; i < 8; i++) begin
            logic [31:0] id = $urandom();
            logic [31:0] mg = $urandom();
            logic [4:0] sh = 5'($urandom());
            run_one("R6 multiply", id, 2'b11, sh, 3'd0, mg, raw_mul(id, mg, 1'b0, sh));
            run_one("R8 round-down", id, 2'b11, sh, 3'd1, mg, raw_mul(id, mg, 1'b1, sh));
        end
        run_one("R8 extreme", 32'hFFFF_FFFF, 2'b11, 5'd0, 3'd1, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_one("R6 no preshift", 32'd7, 2'b11, 5'd0, 3'd0, 32'h8000_0000, 32'd3);
    endtask

    task automatic t_bit31();
        for (int i = 0; i < 4; i++) begin
            logic [31:0] id = $urandom();
            logic [31:0] mg = $urandom();
            logic [4:0] sh = 5'($urandom());
            logic [31:0] e = raw_mul(id, mg, 1'b0, sh);
            run_one("R7 bit31 set", id, 2'b11, sh, 3'd0, mg | 32'h8000_0000, e);
            run_one("R7 bit31 clear", id, 2'b11, sh, 3'd0, mg & 32'h7FFF_FFFF, e);
        end
    endtask

    task automatic t_divide();
        logic [31:0] divs [8] = '{32'd1, 32'd3, 32'd7, 32'd72, 32'd640, 32'd1000003,
                                   32'h8000_0000, 32'hFFFF_FFFF};
        for (int j = 0; j < 8; j++) begin
            logic [31:0] d = divs[j];
            logic [4:0]  s = '0;
            logic [63:0] num, q, e, m;
            logic [31:0] mg;
            logic        fl;
            for (int b = 0; b < 32; b++) if (d[b]) s = 5'(b);
            num = 64'd1 << (32 + int'(s));
            q = num / {32'b0, d};
            e = num % {32'b0, d};
            m = (e != 0) ? q + 1 : q;
            if (e <= (64'd1 << s)) begin mg = 32'(m - 1); fl = 1'b1; end
            else begin mg = 32'(m); fl = 1'b0; end
            run_one("R9 id=max", 32'hFFFF_FFFF, 2'b11, s, {2'b0, fl}, mg, 32'hFFFF_FFFF / d);
            run_one("R9 id=d", d, 2'b11, s, {2'b0, fl}, mg, 32'd1);
            for (int i = 0; i < 3; i++) begin
                logic [31:0] id = $urandom();
                run_one("R9 random", id, 2'b11, s, {2'b0, fl}, mg, id / d);
            end
        end
    endtask

    task automatic t_stream();
        logic [31:0] ids [4];
        for (int k = 0; k < 4; k++) ids[k] = $urandom();
        for (int k = 0; k < 7; k++) begin
            @(negedge clk);
            if (k >= 2 && k <= 5) begin
                check("R2 stream valid", {31'b0, out_valid}, 32'd1);
                check("R2 stream order", elem_idx, ids[k-2] >> 2);
            end else begin
                check("R2 stream idle", {31'b0, out_valid}, 32'd0);
            end
            if (k < 4) begin
                in_valid = 1'b1; lin_id = ids[k]; mode = 2'b10; shift_amt = 5'd2;
            end else begin
                in_valid = 1'b0;
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        t_reset();
        t_pass();
        t_mod();
        t_pow2();
        t_raw();
        t_bit31();
        t_divide();
        t_stream();
        if (!done) begin
            done = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog got timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule